// File: doc/BRIEF.md
# Marker-Framed Serial Audio to I2S Converter

This block is glue logic between a serial audio source that frames each stereo sample with a short word-clock pulse and a receiver that expects a standard two-channel serial stream with a 50 % duty left/right clock. The source raises its marker only at the start of the left channel. No edge marks the right channel, so the block counts bit clocks from the marker to find it. It captures both channel words, holds them for one frame, and plays them out again with a regenerated left/right clock. The data is placed either one bit after each clock transition (I2S) or right on it (left-justified).

All logic runs on the incoming bit clock. Inputs are sampled on its rising edge and outputs are launched on its falling edge, so the receiver sees stable data around every rising edge. The slot length per channel and the carried word length are parameters. At 44.1 kHz with 32-bit slots the bit clock is 2.8224 MHz, which is 11.2896 MHz (256 times the sample rate) divided by four. A marker that arrives where the count does not expect one raises a sticky flag, and framing restarts at that marker.

Top module: `pulse_i2s_conv`

## Requirements
- R1: A rising edge of `ws_pulse_i`, sampled on a rising bit-clock edge, marks the bit sampled in that cycle as the first (MSB) bit of the left slot. Each following bit is counted, and the right slot starts `SLOT_W` bits after the left one. A frame is `2*SLOT_W` bits long.
- R2: Once framing is established, `lrclk_o` is low for the left channel and high for the right channel. Each level lasts exactly `SLOT_W` bit clocks.
- R3: With `lj_mode_i` = 0 (I2S), the MSB of each channel word appears on `sd_o` one bit clock after the `lrclk_o` transition that opens its slot.
- R4: With `lj_mode_i` = 1 (left-justified), the MSB of each channel word appears on `sd_o` in the same bit clock as the `lrclk_o` transition.
- R5: Words are carried MSB first (sign bit first), using the first `WORD_W` bits of each input slot. Input slot bits past `WORD_W` are ignored, and the matching output bits are driven 0.
- R6: When `SLOT_W` < `WORD_W`, only the first `SLOT_W` bits (the MSBs) of each word are carried, and the remaining LSBs are dropped.
- R7: The words captured in one input frame are played out in the output frame that starts at the next frame boundary. The first output left-slot transition is seen `2*SLOT_W + 1` rising edges after the marker that opened the captured frame.
- R8: `bclk_o` follows `bclk_i`. `lrclk_o` and `sd_o` change only on falling bit-clock edges.
- R9: After reset, and until the first marker edge, `lrclk_o`, `sd_o` and `resync_o` are low, whatever arrives on `sd_i`.
- R10: A marker edge that arrives while locked, at any bit other than the first bit of a new frame, sets `resync_o`. The flag stays set until reset, and framing restarts with that bit as the left MSB.
- R11: A marker edge that arrives exactly at a frame boundary does not set `resync_o`. A marker held high for more than one bit clock counts as a single marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Incoming bit clock; all logic runs on it |
| rst_i | input | 1 | Synchronous active-high reset |
| ws_pulse_i | input | 1 | Short marker pulse at the start of the left slot |
| sd_i | input | 1 | Serial input data, MSB first |
| lj_mode_i | input | 1 | Output placement: 0 = I2S one-bit delay, 1 = left-justified |
| bclk_o | output | 1 | Regenerated bit clock for the receiver |
| lrclk_o | output | 1 | 50 % duty left/right clock, low for left |
| sd_o | output | 1 | Realigned serial output data |
| resync_o | output | 1 | Sticky flag for a marker at an unexpected bit count |

## Verification
The bench builds two instances. One uses 32-bit slots with 24-bit words; the bench drives its padding bits high, so zero-fill on the output can be observed. The other uses 16-bit slots with 24-bit words, which gives a 32-bit frame and brings LSB truncation within reach. Both instances run I2S and left-justified traffic with sign-heavy and alternating patterns, a latency measurement from the first marker, and an early marker that must restart framing and leave the flag set.

// File: rtl/pfi2s_pkg.sv
package pfi2s_pkg;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } out_fmt_e;

    typedef struct packed {
        logic locked;
        logic resync;
    } frm_stat_t;

    function automatic int keep_bits(input int slot_w, input int word_w);
        return (slot_w < word_w) ? slot_w : word_w;
    endfunction

endpackage

// File: rtl/pfi2s_framer.sv
module pfi2s_framer
    import pfi2s_pkg::*;
#(
    parameter int FRAME_W = 64,
    parameter int PW      = $clog2(FRAME_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ws_i,
    output logic [PW-1:0] pos_q,
    output logic [PW-1:0] pos_d,
    output logic          take,
    output frm_stat_t     stat
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

    logic          ws_q;
    logic          rise;
    logic          early;
    logic [PW-1:0] wrapped;

    always_comb begin
        rise    = ws_i & ~ws_q;
        wrapped = (pos_q == LAST) ? '0 : pos_q + 1'b1;
        pos_d   = rise ? '0 : wrapped;
        take    = stat.locked | rise;
        early   = rise & stat.locked & (pos_q != LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q        <= 1'b0;
            pos_q       <= '0;
            stat.locked <= 1'b0;
            stat.resync <= 1'b0;
        end else begin
            ws_q <= ws_i;
            if (take) begin
                pos_q <= pos_d;
            end
            stat.locked <= stat.locked | rise;
            stat.resync <= stat.resync | early;
        end
    end

    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        stat.locked |=> stat.locked);  // R1

    AST_RESYNC_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat.resync |=> stat.resync);  // R10

    AST_EARLY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (rise && stat.locked && pos_q != LAST) |=> (stat.resync && pos_q == '0));  // R10

    AST_ON_TIME_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rise && stat.locked && pos_q == LAST) |=> $stable(stat.resync));  // R11

endmodule

// File: rtl/pfi2s_capture.sv
module pfi2s_capture
    import pfi2s_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int WORD_W = 24,
    parameter int PW     = $clog2(2 * SLOT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sd_i,
    input  logic              take_i,
    input  logic [PW-1:0]     pos_d_i,
    output logic [WORD_W-1:0] hold_l_o,
    output logic [WORD_W-1:0] hold_r_o
);
    localparam int KEEP = keep_bits(SLOT_W, WORD_W);

    logic [WORD_W-1:0] acc_l;
    logic [WORD_W-1:0] acc_r;
    logic              in_right;
    logic [PW-1:0]     idx;

    always_comb begin
        in_right = (pos_d_i >= PW'(SLOT_W));
        idx      = in_right ? (pos_d_i - PW'(SLOT_W)) : pos_d_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_l    <= '0;
            acc_r    <= '0;
            hold_l_o <= '0;
            hold_r_o <= '0;
        end else if (take_i) begin
            for (int k = 0; k < KEEP; k++) begin
                if (idx == PW'(k)) begin
                    if (in_right) acc_r[WORD_W-1-k] <= sd_i;
                    else          acc_l[WORD_W-1-k] <= sd_i;
                end
            end
            if (pos_d_i == '0) begin
                hold_l_o <= acc_l;
                hold_r_o <= acc_r;
            end
        end
    end

    AST_HOLD_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
        !(take_i && pos_d_i == '0) |=> ($stable(hold_l_o) && $stable(hold_r_o)));  // R7

endmodule

// File: rtl/pfi2s_emit.sv
module pfi2s_emit
    import pfi2s_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int WORD_W = 24,
    parameter int PW     = $clog2(2 * SLOT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              locked_i,
    input  out_fmt_e          fmt_i,
    input  logic [PW-1:0]     pos_q_i,
    input  logic [WORD_W-1:0] hold_l_i,
    input  logic [WORD_W-1:0] hold_r_i,
    output logic              lrclk_o,
    output logic              sd_o
);
    localparam int KEEP = keep_bits(SLOT_W, WORD_W);

    logic              right;
    logic [PW-1:0]     idx;
    logic [WORD_W-1:0] word;
    logic              lj_bit;
    logic              lj_q;

    always_comb begin
        right  = (pos_q_i >= PW'(SLOT_W));
        idx    = right ? (pos_q_i - PW'(SLOT_W)) : pos_q_i;
        word   = right ? hold_r_i : hold_l_i;
        lj_bit = 1'b0;
        for (int k = 0; k < KEEP; k++) begin
            if (idx == PW'(k)) lj_bit = word[WORD_W-1-k];
        end
    end

    always_ff @(negedge clk) begin
        if (rst || !locked_i) begin
            lrclk_o <= 1'b0;
            lj_q    <= 1'b0;
            sd_o    <= 1'b0;
        end else begin
            lrclk_o <= right;
            lj_q    <= lj_bit;
            sd_o    <= (fmt_i == FMT_LJ) ? lj_bit : lj_q;
        end
    end

endmodule

// File: rtl/pulse_i2s_conv.sv
module pulse_i2s_conv
    import pfi2s_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int WORD_W = 24
) (
    input  logic bclk_i,
    input  logic rst_i,
    input  logic ws_pulse_i,
    input  logic sd_i,
    input  logic lj_mode_i,
    output logic bclk_o,
    output logic lrclk_o,
    output logic sd_o,
    output logic resync_o
);
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int PW      = $clog2(FRAME_W);

    logic [PW-1:0]     pos_q;
    logic [PW-1:0]     pos_d;
    logic              take;
    frm_stat_t         stat;
    logic [WORD_W-1:0] hold_l;
    logic [WORD_W-1:0] hold_r;
    out_fmt_e          fmt;

    assign bclk_o   = bclk_i;
    assign resync_o = stat.resync;
    assign fmt      = out_fmt_e'(lj_mode_i);

    pfi2s_framer #(.FRAME_W(FRAME_W), .PW(PW)) u_framer (
        .clk   (bclk_i),
        .rst   (rst_i),
        .ws_i  (ws_pulse_i),
        .pos_q (pos_q),
        .pos_d (pos_d),
        .take  (take),
        .stat  (stat)
    );

    pfi2s_capture #(.SLOT_W(SLOT_W), .WORD_W(WORD_W), .PW(PW)) u_capture (
        .clk      (bclk_i),
        .rst      (rst_i),
        .sd_i     (sd_i),
        .take_i   (take),
        .pos_d_i  (pos_d),
        .hold_l_o (hold_l),
        .hold_r_o (hold_r)
    );

    pfi2s_emit #(.SLOT_W(SLOT_W), .WORD_W(WORD_W), .PW(PW)) u_emit (
        .clk      (bclk_i),
        .rst      (rst_i),
        .locked_i (stat.locked),
        .fmt_i    (fmt),
        .pos_q_i  (pos_q),
        .hold_l_i (hold_l),
        .hold_r_i (hold_r),
        .lrclk_o  (lrclk_o),
        .sd_o     (sd_o)
    );

    AST_LR_TRACKS_COUNT: assert property (@(posedge bclk_i) disable iff (rst_i)
        stat.locked |-> (lrclk_o == (pos_q >= PW'(SLOT_W))));  // R2

    AST_QUIET_UNLOCKED: assert property (@(posedge bclk_i) disable iff (rst_i)
        !stat.locked |-> (!lrclk_o && !sd_o && !resync_o));  // R9

endmodule

// File: tb/tb_pulse_i2s_conv.sv
`timescale 1ns/1ps

module tb_pulse_i2s_run #(
    parameter int SLOT_W = 32,
    parameter int WORD_W = 24
);
    localparam int FRAME_W = 2 * SLOT_W;
    typedef logic [FRAME_W-1:0] frm_t;
    typedef logic [WORD_W-1:0]  word_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ws  = 1'b0;
    logic sd  = 1'b0;
    logic lj  = 1'b0;
    logic bclk, lrclk, sdo, resync;

    always #5 clk = ~clk;

    pulse_i2s_conv #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) dut (
        .bclk_i     (clk),
        .rst_i      (rst),
        .ws_pulse_i (ws),
        .sd_i       (sd),
        .lj_mode_i  (lj),
        .bclk_o     (bclk),
        .lrclk_o    (lrclk),
        .sd_o       (sdo),
        .resync_o   (resync)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    int   cyc = 0;
    int   edge_viol = 0;
    int   mark_cyc = 0;
    int   first_fall_cyc = -1;
    bit   mon_en = 1'b0;
    frm_t expq[$];

    always @(negedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected output frame: word MSB first, padding zero, LSBs cut when slot is short
    function automatic frm_t exp_frame(input word_t l, input word_t r);
        frm_t v = '0;
        for (int i = 0; i < SLOT_W; i++) begin
            if (i < WORD_W) begin
                v[FRAME_W-1-i] = l[WORD_W-1-i];
                v[SLOT_W-1-i]  = r[WORD_W-1-i];
            end
        end
        return v;
    endfunction

    // Input stream bit; padding bits are driven high so zero-fill is visible
    function automatic logic in_bit(input word_t l, input word_t r, input int n);
        int i = n % SLOT_W;
        if (i >= WORD_W) return 1'b1;
        return (n >= SLOT_W) ? r[WORD_W-1-i] : l[WORD_W-1-i];
    endfunction

    function automatic word_t pattern(input int k);
        word_t w = '0;
        case (k % 6)
            0: w[WORD_W-1] = 1'b1;
            1: w = '1;
            2: begin w = '1; w[WORD_W-1] = 1'b0; end
            3: for (int i = 0; i < WORD_W; i++) w[i] = i[0];
            4: w = '0;
            default: w = word_t'($urandom);
        endcase
        return w;
    endfunction

    task automatic send_bits(input word_t l, input word_t r, input int nbits,
                             input int en_at, input int dis_at);
        for (int n = 0; n < nbits; n++) begin
            @(negedge clk);
            #1;
            ws = (n < 2);
            sd = in_bit(l, r, n);
            if (n == 0) mark_cyc = cyc;
            if (n == en_at)  mon_en = 1'b1;
            if (n == dis_at) mon_en = 1'b0;
        end
    endtask

    function automatic string frame_tags();
        string t;
        t = lj ? "R1 R4" : "R1 R3";
        t = {t, (WORD_W > SLOT_W) ? " R6" : " R5"};
        return t;
    endfunction

    // Monitor: decode frames from lrclk falls and compare with the scoreboard
    int   m_n = 0;
    int   m_run = 0;
    bit   m_act = 1'b0;
    bit   m_have_edge = 1'b0;
    logic m_prev = 1'b0;
    frm_t m_got = '0;

    always @(posedge clk) begin
        if (!mon_en) begin
            m_act = 1'b0;
            m_have_edge = 1'b0;
        end else begin
            if (m_act) begin
                m_got[FRAME_W-1-m_n] = sdo;
                m_n++;
                if (m_n == FRAME_W) begin
                    m_act = 1'b0;
                    if (expq.size() == 0) begin
                        check(1'b0, "R7", "unexpected output frame", m_got, '0);
                    end else begin
                        frm_t e;
                        e = expq.pop_front();
                        check(m_got === e, frame_tags(), "output frame", m_got, e);
                    end
                end
            end
            if (m_prev && !lrclk) begin
                if (first_fall_cyc < 0) first_fall_cyc = cyc;
                m_act = 1'b1;
                m_n = 0;
                if (lj) begin
                    m_got[FRAME_W-1] = sdo;
                    m_n = 1;
                end
            end
            if (lrclk != m_prev) begin
                if (m_have_edge) check(m_run == SLOT_W, "R2", "lrclk level length", m_run, SLOT_W);
                m_have_edge = 1'b1;
                m_run = 1;
            end else begin
                m_run++;
            end
        end
        m_prev = lrclk;
    end

    // R8: outputs must not move at the rising edge; bclk_o follows the clock
    always @(posedge clk) begin
        logic a, b;
        a = lrclk;
        b = sdo;
        #1;
        if (a !== lrclk || b !== sdo) edge_viol++;
        if (bclk !== 1'b1) edge_viol++;
    end

    task automatic do_reset(input logic mode);
        @(negedge clk);
        #1;
        mon_en = 1'b0;
        rst = 1'b1;
        ws = 1'b0;
        sd = 1'b0;
        lj = mode;
        expq.delete();
        repeat (3) @(negedge clk);
        #2;
        check(lrclk === 1'b0 && sdo === 1'b0 && resync === 1'b0, "R9", "reset state",
              {lrclk, sdo, resync}, 3'b000);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            sd = ~sd;
        end
        @(negedge clk);
        #2;
        check(lrclk === 1'b0 && sdo === 1'b0 && resync === 1'b0, "R9", "quiet before first marker",
              {lrclk, sdo, resync}, 3'b000);
    endtask

    task automatic run_normal(input logic mode, input int nfr, input bit time_chk);
        int start_cyc;
        do_reset(mode);
        first_fall_cyc = -1;
        mon_en = 1'b1;
        start_cyc = 0;
        for (int f = 0; f < nfr; f++) begin
            word_t l, r;
            l = pattern(2 * f);
            r = pattern(2 * f + 1);
            expq.push_back(exp_frame(l, r));
            send_bits(l, r, FRAME_W, -1, -1);
            if (f == 0) start_cyc = mark_cyc;
        end
        send_bits('0, '0, FRAME_W, -1, -1);
        send_bits('0, '0, FRAME_W, -1, FRAME_W / 2);
        check(expq.size() == 0, "R7", "frames still pending", expq.size(), 0);
        check(resync === 1'b0, "R11", "on-time markers leave flag clear", resync, 1'b0);
        if (time_chk)
            check(first_fall_cyc == start_cyc + FRAME_W + 1, "R7", "first output frame timing",
                  first_fall_cyc, start_cyc + FRAME_W + 1);
    endtask

    task automatic run_resync();
        word_t a, b, dl, dr;
        a  = pattern(3);
        b  = pattern(0);
        dl = pattern(0);
        dr = pattern(3);
        do_reset(1'b0);
        send_bits(a, b, FRAME_W, -1, -1);
        send_bits(a, b, FRAME_W, -1, -1);
        check(resync === 1'b0, "R11", "flag clear while on time", resync, 1'b0);
        send_bits(a, b, 10, -1, -1);
        send_bits(dl, dr, FRAME_W, -1, -1);
        check(resync === 1'b1, "R10", "early marker sets flag", resync, 1'b1);
        for (int i = 0; i < 3; i++) expq.push_back(exp_frame(dl, dr));
        send_bits(dl, dr, FRAME_W, -1, -1);
        send_bits(dl, dr, FRAME_W, 3, -1);
        send_bits(dl, dr, FRAME_W, -1, -1);
        send_bits(dl, dr, FRAME_W, -1, -1);
        send_bits('0, '0, FRAME_W, -1, -1);
        send_bits('0, '0, FRAME_W, -1, FRAME_W / 2);
        check(expq.size() == 0, "R10", "framing restarted at early marker", expq.size(), 0);
        check(resync === 1'b1, "R10", "flag stays set", resync, 1'b1);
    endtask

    initial begin
        run_normal(1'b0, 8, 1'b1);
        run_normal(1'b1, 8, 1'b0);
        run_resync();
        check(edge_viol == 0, "R8", "output change off the falling edge", edge_viol, 0);
        done = 1'b1;
    end

endmodule

module tb_pulse_i2s_conv;
    tb_pulse_i2s_run #(.SLOT_W(32), .WORD_W(24)) u_wide ();
    tb_pulse_i2s_run #(.SLOT_W(16), .WORD_W(24)) u_narrow ();

    initial begin
        int waited;
        int chk;
        int bad;
        waited = 0;
        while (!(u_wide.done && u_narrow.done) && waited < 150000) begin
            #10;
            waited++;
        end
        chk = u_wide.n_chk + u_narrow.n_chk;
        bad = u_wide.n_fail + u_narrow.n_fail;
        if (!(u_wide.done && u_narrow.done)) begin
            chk++;
            bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", chk, bad);
        $finish;
    end
endmodule